// File: doc/BRIEF.md
# Truncated Ripple Modulo Counter

This block is an up-counter built as a chain of toggle stages. Each stage changes state on the falling edge of its own clock. The first stage takes the count clock. Every later stage is clocked by the output of the stage below it, so a carry travels up the chain one stage at a time.

The count is cut short by a terminal-state detector. It watches only the count bits that are 1 in the modulus. When all of those bits are high at once, it pulls an active-low clear that reaches every stage asynchronously. The counter therefore touches the state equal to the modulus only for an instant and then settles at zero. Once the tapped bits are zero, the clear releases by itself and counting resumes.

The modulus `MOD` is a parameter with a default of 10, which gives a decade counter. The stage count defaults to the smallest width that can hold `MOD` states. When `MOD` is an exact power of two, no detector is built and the chain wraps on its own. A registered wrap flag, timed to the count clock, marks each pass from `MOD-1` back to zero. The block suits frequency division and decimal counting, where downstream logic reads the count only after the ripple has settled.

Top module: `trunc_ripple_counter`

## Requirements
- R1: Each falling edge of `clk_cnt_i` advances the settled value on `count_o` by one. Bit 0 is the least significant bit.
- R2: The settled count runs from 0 up to `MOD-1` and then returns to 0, so `count_o` never settles at `MOD` or above. With the default `MOD` of 10, the tenth edge after reset gives 0 and the eleventh gives 1.
- R3: The clear fires when every count bit that is 1 in `MOD` is high. For `MOD` = 12 these are bit 3 and bit 2, so the value 12 (binary 1100) clears at once and 11 is followed by 0. The clear is inactive whenever the count has settled.
- R4: The width of `count_o` defaults to the smallest n with 2^n >= `MOD`, for example 6 bits when `MOD` = 40. A `MOD` above 2^`WIDTH`, or below 2, stops elaboration with an error.
- R5: While `rst_cnt_ni` is low, `count_o` and `wrap_pulse_o` are 0, and falling clock edges have no effect. The clear takes effect without waiting for a clock. After release, the first falling edge gives a count of 1.
- R6: `wrap_pulse_o` is 1 for exactly one clock period. It rises on the falling edge that takes the count from `MOD-1` to 0 and falls on the next falling edge. It is 0 at every other time, including the zero that follows reset.
- R7: When `MOD` equals 2^`WIDTH` (for example 16), the chain runs its full sequence without a detector and wraps from `MOD-1` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_cnt_i | input | 1 | Count clock; the falling edge advances the count |
| rst_cnt_ni | input | 1 | Asynchronous reset, active low, merged into the stage clear |
| count_o | output | WIDTH | Count value, bit 0 least significant |
| wrap_pulse_o | output | 1 | One-period flag raised when the count wraps to zero |

## Verification
The default decade counter is walked through more than two full cycles against a table, which separates correct truncation at ten from a counter that runs on to eleven or stops at nine. A modulo-12 copy taps only the upper two bits, so a wrong tap choice shows up as an early or late wrap. A modulo-16 copy exercises the variant without a detector, where any leftover clear logic would cut the sequence short. A modulo-40 copy checks the derived six-bit width and the wrap from 39, which needs carries through several stages. A reset applied in the middle of a count shows whether the clear acts asynchronously, whether clock edges are ignored while reset is held, and whether the wrap flag ignores the zero that follows reset.

// File: rtl/rctr_pkg.sv
package rctr_pkg;

   // Variant picked at elaboration from the modulus
   typedef enum logic {
      WRAP_NATURAL   = 1'b0,
      WRAP_TRUNCATED = 1'b1
   } rctr_wrap_e;

   // Decide whether the chain needs a clear detector for this modulus
   function automatic rctr_wrap_e wrap_kind(input int unsigned modulus,
                                            input int unsigned width);
      longint unsigned span;
      span = 64'(1) << width;
      return (longint'(modulus) == span) ? WRAP_NATURAL : WRAP_TRUNCATED;
   endfunction

   // Bits set in the modulus are the detector taps
   function automatic logic [31:0] tap_mask(input int unsigned modulus);
      return 32'(modulus);
   endfunction

endpackage

// File: rtl/rctr_toggle_stage.sv
// One divide-by-two cell: toggles on the falling edge of step_ni,
// forced to zero while clr_ni is low.
module rctr_toggle_stage (
   input  logic step_ni,
   input  logic clr_ni,
   output logic q_o
);

   always_ff @(negedge step_ni or negedge clr_ni) begin
      if (!clr_ni) q_o <= 1'b0;
      else         q_o <= ~q_o;
   end

endmodule

// File: rtl/rctr_clear_detect.sv
// Terminal-state detector: NAND of the tapped count bits, merged with the
// external reset into one active-low clear.
module rctr_clear_detect #(
   parameter int unsigned WIDTH = 4,
   parameter logic [WIDTH-1:0] MASK = 4'b1010
) (
   input  logic [WIDTH-1:0] cnt_i,
   input  logic             rst_ni,
   output logic             clr_no
);

   logic [WIDTH-1:0] tap;
   logic             hit;

   // Untapped bits read as 1, so only the modulus bits decide
   for (genvar k = 0; k < WIDTH; k++) begin : g_tap
      if (MASK[k]) begin : g_use
         assign tap[k] = cnt_i[k];
      end else begin : g_skip
         assign tap[k] = 1'b1;
      end
   end

   assign hit    = &tap;
   assign clr_no = rst_ni & ~hit;

endmodule

// File: rtl/rctr_term_flag.sv
// Wrap flag: registered on the count clock, set when the count leaving the
// edge was MOD-1, so it spans exactly one clock period.
module rctr_term_flag #(
   parameter int unsigned WIDTH = 4,
   parameter int unsigned MOD   = 10
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] cnt_i,
   output logic             pulse_o
);

   localparam logic [WIDTH-1:0] LAST = WIDTH'(MOD - 1);

   always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pulse_o <= 1'b0;
      else         pulse_o <= (cnt_i == LAST);
   end

endmodule

// File: rtl/trunc_ripple_counter.sv
module trunc_ripple_counter
   import rctr_pkg::*;
#(
   parameter int unsigned MOD   = 10,
   parameter int unsigned WIDTH = $clog2(MOD)
) (
   input  logic             clk_cnt_i,
   input  logic             rst_cnt_ni,
   output logic [WIDTH-1:0] count_o,
   output logic             wrap_pulse_o
);

   localparam rctr_wrap_e       KIND  = wrap_kind(MOD, WIDTH);
   localparam logic [31:0]      MASKW = tap_mask(MOD);
   localparam logic [WIDTH-1:0] MASK  = MASKW[WIDTH-1:0];

   // Parameter checks (R4)
   if (MOD < 2) begin : g_bad_small
      $error("trunc_ripple_counter: MOD must be at least 2");
   end
   if (WIDTH > 31) begin : g_bad_wide
      $error("trunc_ripple_counter: WIDTH too large");
   end
   if (longint'(MOD) > (64'(1) << WIDTH)) begin : g_bad_mod
      $error("trunc_ripple_counter: MOD exceeds 2**WIDTH");
   end

   logic [WIDTH-1:0] cnt_q;
   logic [WIDTH-1:0] stage_clk;
   logic             clr_n;

   // Clear path: detector for truncated moduli, reset only otherwise (R3, R7)
   if (KIND == WRAP_TRUNCATED) begin : g_trunc
      rctr_clear_detect #(
         .WIDTH (WIDTH),
         .MASK  (MASK)
      ) detect_i (
         .cnt_i  (cnt_q),
         .rst_ni (rst_cnt_ni),
         .clr_no (clr_n)
      );

      // Settled count must never leave the clear asserted (R3)
      assert_clear_idle_R3 : assert property (@(posedge clk_cnt_i)
         disable iff (!rst_cnt_ni) clr_n)
         else $error("clear still active on settled count");
   end else begin : g_full
      assign clr_n = rst_cnt_ni;
   end

   // Ripple chain: stage k is clocked by stage k-1. Later stage clocks are
   // held low while clearing so that bits dropping on a clear give no edge.
   for (genvar k = 0; k < WIDTH; k++) begin : g_stage
      if (k == 0) begin : g_first
         assign stage_clk[k] = clk_cnt_i;
      end else begin : g_next
         assign stage_clk[k] = cnt_q[k-1] & clr_n;
      end

      rctr_toggle_stage stage_i (
         .step_ni (stage_clk[k]),
         .clr_ni  (clr_n),
         .q_o     (cnt_q[k])
      );
   end

   rctr_term_flag #(
      .WIDTH (WIDTH),
      .MOD   (MOD)
   ) flag_i (
      .clk_i   (clk_cnt_i),
      .rst_ni  (rst_cnt_ni),
      .cnt_i   (cnt_q),
      .pulse_o (wrap_pulse_o)
   );

   assign count_o = cnt_q;

   // Checker state: a full clock period has passed since reset release
   logic armed_q;
   always_ff @(posedge clk_cnt_i or negedge rst_cnt_ni) begin
      if (!rst_cnt_ni) armed_q <= 1'b0;
      else             armed_q <= 1'b1;
   end

   assert_below_mod_R2 : assert property (@(posedge clk_cnt_i)
      disable iff (!rst_cnt_ni) int'(count_o) < int'(MOD))
      else $error("count settled at or above modulus");

   assert_step_one_R1 : assert property (@(posedge clk_cnt_i)
      disable iff (!rst_cnt_ni)
      armed_q |-> (int'(count_o) == ((int'($past(count_o)) + 1) % int'(MOD))))
      else $error("count did not advance by one");

   assert_wrap_flag_R6 : assert property (@(posedge clk_cnt_i)
      disable iff (!rst_cnt_ni)
      armed_q |-> (wrap_pulse_o == (count_o == '0)))
      else $error("wrap flag does not match wrap");

   assert_flag_single_R6 : assert property (@(posedge clk_cnt_i)
      disable iff (!rst_cnt_ni)
      wrap_pulse_o |=> !wrap_pulse_o)
      else $error("wrap flag longer than one period");

endmodule

// File: tb/trunc_ripple_counter_tb_top.sv
`timescale 1ns/1ps
module trunc_ripple_counter_tb_top;

   localparam time CLK_PERIOD = 8ns;   // 125 MHz
   localparam int  N_TAB = 22;

   // {expected wrap flag, expected 4-bit count} after each falling edge, MOD 10
   localparam logic [4:0] EXP_TAB [N_TAB] = '{
      5'h01, 5'h02, 5'h03, 5'h04, 5'h05, 5'h06, 5'h07, 5'h08, 5'h09, 5'h10,
      5'h01, 5'h02, 5'h03, 5'h04, 5'h05, 5'h06, 5'h07, 5'h08, 5'h09, 5'h10,
      5'h01, 5'h02
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;

   logic [3:0] cnt10;
   logic [3:0] cnt12;
   logic [3:0] cnt16;
   logic [5:0] cnt40;
   logic       w10, w12, w16, w40;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;
   int r12 = 0, r16 = 0, r40 = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   trunc_ripple_counter #(.MOD(10)) dut_i (
      .clk_cnt_i(clk), .rst_cnt_ni(rst_n), .count_o(cnt10), .wrap_pulse_o(w10));
   trunc_ripple_counter #(.MOD(12)) dut12_i (
      .clk_cnt_i(clk), .rst_cnt_ni(rst_n), .count_o(cnt12), .wrap_pulse_o(w12));
   trunc_ripple_counter #(.MOD(16)) dut16_i (
      .clk_cnt_i(clk), .rst_cnt_ni(rst_n), .count_o(cnt16), .wrap_pulse_o(w16));
   trunc_ripple_counter #(.MOD(40)) dut40_i (
      .clk_cnt_i(clk), .rst_cnt_ni(rst_n), .count_o(cnt40), .wrap_pulse_o(w40));

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Advance one falling edge, let the ripple settle, update references
   task automatic tick();
      @(negedge clk);
      #2ns;
      r12 = (r12 + 1) % 12;
      r16 = (r16 + 1) % 16;
      r40 = (r40 + 1) % 40;
   endtask

   task automatic check_others();
      chk("R3 mod12 count", int'(cnt12), r12);
      chk("R6 mod12 flag",  int'(w12),   int'(r12 == 0));
      chk("R7 mod16 count", int'(cnt16), r16);
      chk("R7 mod16 flag",  int'(w16),   int'(r16 == 0));
      chk("R4 mod40 count", int'(cnt40), r40);
      chk("R6 mod40 flag",  int'(w40),   int'(r40 == 0));
   endtask

   initial begin
      // R4: derived widths
      chk("R4 width mod10", $bits(cnt10), 4);
      chk("R4 width mod40", $bits(cnt40), 6);

      // R5: reset holds everything at zero across clock edges
      repeat (3) @(negedge clk);
      #2ns;
      chk("R5 reset count", int'(cnt10), 0);
      chk("R5 reset flag",  int'(w10),   0);
      chk("R5 reset mod40", int'(cnt40), 0);
      @(posedge clk);
      #1ns rst_n = 1'b1;

      // R1, R2, R6: table walk for the decade counter
      for (int i = 0; i < N_TAB; i++) begin
         tick();
         chk("R1 R2 count", int'(cnt10), int'(EXP_TAB[i][3:0]));
         chk("R6 flag",     int'(w10),   int'(EXP_TAB[i][4]));
         check_others();
      end

      // Continue until the 6-bit counter has wrapped (R4, R3, R7)
      for (int i = 0; i < 24; i++) begin
         tick();
         chk("R2 count", int'(cnt10), (N_TAB + 1 + i) % 10);
         check_others();
      end

      // R5: reset in mid count acts without a clock, edges ignored
      #1ns rst_n = 1'b0;
      #1ns;
      chk("R5 async clear count", int'(cnt10), 0);
      chk("R5 async clear mod40", int'(cnt40), 0);
      repeat (3) begin
         @(negedge clk);
         #2ns;
         chk("R5 held count", int'(cnt10), 0);
         chk("R5 held flag",  int'(w10),   0);
      end
      r12 = 0; r16 = 0; r40 = 0;
      @(posedge clk);
      #1ns rst_n = 1'b1;
      tick();
      chk("R5 resume count", int'(cnt10), 1);
      check_others();

      // R6: flag rises only on the wrap and clears one period later
      for (int i = 0; i < 9; i++) begin
         tick();
         chk("R6 wrap walk", int'(w10), int'(((i + 2) % 10) == 0));
      end
      tick();
      chk("R6 flag after wrap", int'(w10),   0);
      chk("R2 count after wrap", int'(cnt10), 1);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

endmodule